// File: doc/BRIEF.md
# Aliasing Branch Target Buffer with Secure-Mode Flush

This block is a set-associative branch prediction table. Each entry remembers, for one branch, whether it was last resolved taken or not taken and the address it went to. Fetch presents an address on the lookup port and receives a prediction one cycle later. The resolve port writes the outcome of a finished branch back into the table.

Only the low 32 bits of an address take part in indexing and tagging. Two branches whose addresses differ only above bit 31 therefore land on the same entry and share its history. The direction and target seen by either one are those left by whichever of them updated the entry last. A single-cycle flush pulse invalidates every entry. The core raises it on each entry into or exit from protected enclave mode, so no branch history survives that boundary.

Within a set, replacement is least-recently-used. A lookup hit and an update both count as a use. When an update allocates a new entry, a free way is taken first. Otherwise the least-recently-used way is replaced.

Top module: `branch_target_table`

## Requirements
- R1: After reset the response-valid output is low, and every lookup misses until an update has been made.
- R2: A lookup that misses returns hit 0 with taken 0 and target 0, which means fall through to the next sequential instruction.
- R3: A lookup request in cycle N gives rsp_valid 1 in cycle N+1. For an address updated earlier, it returns hit 1 with the stored direction and target. Cycles without a lookup give rsp_valid 0.
- R4: Address bits above bit 31 are ignored. A lookup whose address differs from an updated one only in those bits hits that entry.
- R5: An update to an entry that already exists overwrites its direction and target. This includes an update from an aliasing address, and it covers a new destination for an indirect branch. The next lookup returns the new values.
- R6: The set index is address bits [IDX_LO+IDX_W-1:IDX_LO], with IDX_W = log2(SETS). The tag is bits [31:IDX_LO+IDX_W]. Up to WAYS branches with different tags in one set are all held at the same time, and branches in other sets do not disturb them.
- R7: When an update brings a new branch into a full set, the way used least recently replaces its entry. Both lookup hits and updates count as uses.
- R8: A flush pulse invalidates every entry in one cycle. A lookup in the same cycle as the flush, and any lookup after it, misses until the entry is updated again.
- R9: An update presented in the same cycle as a flush is discarded.
- R10: A lookup and an update to the same entry in the same cycle return the contents from before the update. The update is visible from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_flush | input | 1 | One-cycle pulse on enclave-mode entry or exit; invalidates the table |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Fetch address to predict |
| up_valid | input | 1 | Resolved-branch update request |
| up_addr | input | 64 | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction (1 = taken) |
| up_target | input | 64 | Resolved destination address |
| rsp_valid | output | 1 | Response for the lookup of the previous cycle |
| rsp_hit | output | 1 | Lookup found a valid matching entry |
| rsp_taken | output | 1 | Predicted direction |
| rsp_target | output | 64 | Predicted target address |

## Verification
The bench instantiates the table with 4 sets and 4 ways, keeping 32 address bits and starting the index at bit 2. With only 2 index bits, a handful of addresses that are multiples of 0x1000 all fall into set 0 with distinct tags. This lets a short sequence fill a set, overflow it and show which entry the replacement order evicts. It also reaches aliasing through bits 63:32, overlap of lookup and update on one entry, and updates that arrive together with a flush.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Width of a virtual address and of a stored target
    localparam int unsigned BTB_VA_W = 64;

    // Predicted outcome held by one entry
    typedef struct packed {
        logic                taken;
        logic [BTB_VA_W-1:0] target;
    } btb_pred_t;

    // Reason an update picked the way it writes
    typedef enum logic [1:0] {
        PICK_HIT  = 2'd0,
        PICK_FREE = 2'd1,
        PICK_LRU  = 2'd2
    } btb_pick_e;

    // Empty prediction handed out on a miss: fall through
    function automatic btb_pred_t pred_or_none(input logic hit, input btb_pred_t p);
        btb_pred_t r;
        r = hit ? p : '0;
        return r;
    endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split
    import btb_pkg::*;
#(
    parameter int unsigned SETS   = 1024,
    parameter int unsigned KEEP_W = 32,
    parameter int unsigned IDX_LO = 2,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned TAG_W = KEEP_W - IDX_LO - IDX_W
) (
    input  logic [BTB_VA_W-1:0] addr,
    output logic [IDX_W-1:0]    idx,
    output logic [TAG_W-1:0]    tag
);
    // Bits above KEEP_W and below IDX_LO never reach the table
    logic unused_bits;
    assign unused_bits = ^{addr[BTB_VA_W-1:KEEP_W], addr[IDX_LO-1:0]};

    assign idx = addr[IDX_LO +: IDX_W];
    assign tag = addr[KEEP_W-1:IDX_LO+IDX_W];
endmodule

// File: rtl/btb_way.sv
module btb_way
    import btb_pkg::*;
#(
    parameter int unsigned SETS  = 1024,
    parameter int unsigned TAG_W = 20,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    // lookup read port
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output btb_pred_t        rd_pred,
    // probe port used by the update path
    input  logic [IDX_W-1:0] pr_idx,
    output logic             pr_valid,
    output logic [TAG_W-1:0] pr_tag,
    // write port
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  btb_pred_t        wr_pred
);
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    btb_pred_t        pred_q [SETS];

    // Valid bits live in flops so the whole way clears in one cycle
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            pred_q[wr_idx] <= wr_pred;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_pred  = pred_q[rd_idx];

    assign pr_valid = valid_q[pr_idx];
    assign pr_tag   = tag_q[pr_idx];
endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
    parameter int unsigned SETS = 1024,
    parameter int unsigned WAYS = 4,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    // first use (lookup hit)
    input  logic             ta_en,
    input  logic [IDX_W-1:0] ta_idx,
    input  logic [WAY_W-1:0] ta_way,
    // second use (update); applied after the first
    input  logic             tb_en,
    input  logic [IDX_W-1:0] tb_idx,
    input  logic [WAY_W-1:0] tb_way,
    // victim query
    input  logic [IDX_W-1:0] q_idx,
    output logic [WAY_W-1:0] q_victim
);
    typedef logic [WAYS-1:0][WAY_W-1:0] age_row_t;

    age_row_t age_q [SETS];
    age_row_t row_a_next;
    age_row_t row_b_base;
    age_row_t row_b_next;

    // Make way w the youngest; ways younger than it grow one step older
    function automatic age_row_t touch(input age_row_t r, input logic [WAY_W-1:0] w);
        age_row_t o;
        for (int i = 0; i < WAYS; i++) begin
            if (WAY_W'(i) == w) begin
                o[i] = '0;
            end else if (r[i] < r[w]) begin
                o[i] = r[i] + 1'b1;
            end else begin
                o[i] = r[i];
            end
        end
        return o;
    endfunction

    always_comb begin
        row_a_next = touch(age_q[ta_idx], ta_way);
        row_b_base = (ta_en && (ta_idx == tb_idx)) ? row_a_next : age_q[tb_idx];
        row_b_next = touch(row_b_base, tb_way);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int i = 0; i < WAYS; i++) begin
                    age_q[s][i] <= WAY_W'(i);
                end
            end
        end else begin
            if (ta_en) begin
                age_q[ta_idx] <= row_a_next;
            end
            if (tb_en) begin
                age_q[tb_idx] <= row_b_next;
            end
        end
    end

    // Oldest way carries the largest age
    always_comb begin
        q_victim = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (age_q[q_idx][i] == WAY_W'(WAYS - 1)) begin
                q_victim = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/branch_target_table.sv
module branch_target_table
    import btb_pkg::*;
#(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned SETS   = 1024,
    parameter int unsigned KEEP_W = 32,
    parameter int unsigned IDX_LO = 2,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned TAG_W = KEEP_W - IDX_LO - IDX_W,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_flush,
    input  logic                lk_valid,
    input  logic [BTB_VA_W-1:0] lk_addr,
    input  logic                up_valid,
    input  logic [BTB_VA_W-1:0] up_addr,
    input  logic                up_taken,
    input  logic [BTB_VA_W-1:0] up_target,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_taken,
    output logic [BTB_VA_W-1:0] rsp_target
);
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;

    btb_addr_split #(.SETS(SETS), .KEEP_W(KEEP_W), .IDX_LO(IDX_LO)) u_lk_split (
        .addr (lk_addr),
        .idx  (lk_idx),
        .tag  (lk_tag)
    );

    btb_addr_split #(.SETS(SETS), .KEEP_W(KEEP_W), .IDX_LO(IDX_LO)) u_up_split (
        .addr (up_addr),
        .idx  (up_idx),
        .tag  (up_tag)
    );

    // Per-way read results
    logic [WAYS-1:0]  lk_v, up_v, lk_match, up_match, way_wr;
    logic [TAG_W-1:0] lk_t [WAYS];
    logic [TAG_W-1:0] up_t [WAYS];
    btb_pred_t        lk_p [WAYS];

    btb_pred_t        up_pred;
    logic             up_go;
    logic [WAY_W-1:0] up_way;

    assign up_pred.taken  = up_taken;
    assign up_pred.target = up_target;
    // A flush in the same cycle wins over the update
    assign up_go = up_valid && !mode_flush;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        btb_way #(.SETS(SETS), .TAG_W(TAG_W)) u_way (
            .clk      (clk),
            .rst      (rst),
            .flush    (mode_flush),
            .rd_idx   (lk_idx),
            .rd_valid (lk_v[w]),
            .rd_tag   (lk_t[w]),
            .rd_pred  (lk_p[w]),
            .pr_idx   (up_idx),
            .pr_valid (up_v[w]),
            .pr_tag   (up_t[w]),
            .wr_en    (way_wr[w]),
            .wr_idx   (up_idx),
            .wr_tag   (up_tag),
            .wr_pred  (up_pred)
        );
        assign lk_match[w] = lk_v[w] && (lk_t[w] == lk_tag);
        assign up_match[w] = up_v[w] && (up_t[w] == up_tag);
        assign way_wr[w]   = up_go && (up_way == WAY_W'(w));
    end

    // Lookup way selection
    logic             lk_hit;
    logic [WAY_W-1:0] lk_way;
    btb_pred_t        lk_sel;

    always_comb begin
        lk_hit = 1'b0;
        lk_way = '0;
        lk_sel = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) begin
                lk_hit = 1'b1;
                lk_way = WAY_W'(w);
                lk_sel = lk_p[w];
            end
        end
    end

    // Update way selection: existing entry, else lowest free way, else LRU
    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] hit_way, free_way;
    logic             up_hit, up_free;
    btb_pick_e        up_pick;

    always_comb begin
        up_hit   = 1'b0;
        hit_way  = '0;
        up_free  = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (up_match[w]) begin
                up_hit  = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!up_v[w]) begin
                up_free  = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        if (up_hit) begin
            up_pick = PICK_HIT;
        end else if (up_free) begin
            up_pick = PICK_FREE;
        end else begin
            up_pick = PICK_LRU;
        end
        unique case (up_pick)
            PICK_HIT:  up_way = hit_way;
            PICK_FREE: up_way = free_way;
            default:   up_way = lru_way;
        endcase
    end

    logic lk_use;
    assign lk_use = lk_valid && lk_hit && !mode_flush;

    btb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk      (clk),
        .rst      (rst),
        .ta_en    (lk_use),
        .ta_idx   (lk_idx),
        .ta_way   (lk_way),
        .tb_en    (up_go),
        .tb_idx   (up_idx),
        .tb_way   (up_way),
        .q_idx    (up_idx),
        .q_victim (lru_way)
    );

    // Registered response
    btb_pred_t rsp_pred_d;
    assign rsp_pred_d = pred_or_none(lk_use, lk_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_taken  <= 1'b0;
            rsp_target <= '0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_use;
            rsp_taken  <= rsp_pred_d.taken;
            rsp_target <= rsp_pred_d.target;
        end
    end
endmodule

// File: rtl/btb_checker.sv
module btb_checker
    import btb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                mode_flush,
    input logic                lk_valid,
    input logic                up_valid,
    input logic                rsp_valid,
    input logic                rsp_hit,
    input logic                rsp_taken,
    input logic [BTB_VA_W-1:0] rsp_target
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid); // R3

    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid); // R3

    AST_HIT_IMPLIES_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid); // R3

    AST_MISS_FALLS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (!rsp_taken && rsp_target == '0)); // R2

    AST_FLUSH_SAME_CYCLE_MISS: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && mode_flush) |=> !rsp_hit); // R8

    AST_AFTER_FLUSH_MISS: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_flush) && lk_valid) |=> !rsp_hit); // R8 R9
endmodule

bind branch_target_table btb_checker u_btb_checker (
    .clk        (clk),
    .rst        (rst),
    .mode_flush (mode_flush),
    .lk_valid   (lk_valid),
    .up_valid   (up_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_taken  (rsp_taken),
    .rsp_target (rsp_target)
);

// File: tb/tb_branch_target_table.sv
module tb_branch_target_table;
    import btb_pkg::*;

    logic                clk = 1'b0;
    logic                rst;
    logic                mode_flush;
    logic                lk_valid;
    logic [BTB_VA_W-1:0] lk_addr;
    logic                up_valid;
    logic [BTB_VA_W-1:0] up_addr;
    logic                up_taken;
    logic [BTB_VA_W-1:0] up_target;
    logic                rsp_valid;
    logic                rsp_hit;
    logic                rsp_taken;
    logic [BTB_VA_W-1:0] rsp_target;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    branch_target_table #(.WAYS(4), .SETS(4), .KEEP_W(32), .IDX_LO(2)) dut (
        .clk        (clk),
        .rst        (rst),
        .mode_flush (mode_flush),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .up_valid   (up_valid),
        .up_addr    (up_addr),
        .up_taken   (up_taken),
        .up_target  (up_target),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_taken  (rsp_taken),
        .rsp_target (rsp_target)
    );

    // op: 0 = lookup (checked), 1 = update
    typedef struct packed {
        logic        op;
        logic [63:0] addr;
        logic        taken;
        logic [63:0] tgt;
        logic        ehit;
        logic        etaken;
        logic [63:0] etgt;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 25;
    // Set 0 addresses: A=0x1000 B=0x2000 C=0x3000 D=0x4000 F=0x5000 G=0x6000; E=0x5004 is set 1
    localparam vec_t VEC [NV] = '{
        '{1'b0, 64'h1000,              1'b0, 64'h0,    1'b0, 1'b0, 64'h0,    4'd1}, // R1 R2
        '{1'b1, 64'h1000,              1'b1, 64'h2000, 1'b0, 1'b0, 64'h0,    4'd3},
        '{1'b0, 64'h1000,              1'b0, 64'h0,    1'b1, 1'b1, 64'h2000, 4'd3}, // R3
        '{1'b0, 64'hFF00_0000_0000_1000, 1'b0, 64'h0,  1'b1, 1'b1, 64'h2000, 4'd4}, // R4
        '{1'b1, 64'hFF00_0000_0000_1000, 1'b1, 64'h3000, 1'b0, 1'b0, 64'h0,  4'd5},
        '{1'b0, 64'h1000,              1'b0, 64'h0,    1'b1, 1'b1, 64'h3000, 4'd5}, // R5
        '{1'b1, 64'h1000,              1'b0, 64'h1004, 1'b0, 1'b0, 64'h0,    4'd5},
        '{1'b0, 64'hFF00_0000_0000_1000, 1'b0, 64'h0,  1'b1, 1'b0, 64'h1004, 4'd5}, // R5
        '{1'b1, 64'h2000,              1'b1, 64'hB0,   1'b0, 1'b0, 64'h0,    4'd6},
        '{1'b1, 64'h3000,              1'b1, 64'hC0,   1'b0, 1'b0, 64'h0,    4'd6},
        '{1'b1, 64'h4000,              1'b1, 64'hD0,   1'b0, 1'b0, 64'h0,    4'd6},
        '{1'b0, 64'h1000,              1'b0, 64'h0,    1'b1, 1'b0, 64'h1004, 4'd6}, // R6
        '{1'b0, 64'h2000,              1'b0, 64'h0,    1'b1, 1'b1, 64'hB0,   4'd6}, // R6
        '{1'b0, 64'h3000,              1'b0, 64'h0,    1'b1, 1'b1, 64'hC0,   4'd6}, // R6
        '{1'b0, 64'h4000,              1'b0, 64'h0,    1'b1, 1'b1, 64'hD0,   4'd6}, // R6
        '{1'b0, 64'h5004,              1'b0, 64'h0,    1'b0, 1'b0, 64'h0,    4'd6}, // R6
        '{1'b1, 64'h5000,              1'b1, 64'hF0,   1'b0, 1'b0, 64'h0,    4'd7},
        '{1'b0, 64'h1000,              1'b0, 64'h0,    1'b0, 1'b0, 64'h0,    4'd7}, // R7 A evicted
        '{1'b0, 64'h2000,              1'b0, 64'h0,    1'b1, 1'b1, 64'hB0,   4'd7}, // R7
        '{1'b0, 64'h5000,              1'b0, 64'h0,    1'b1, 1'b1, 64'hF0,   4'd7}, // R7
        '{1'b0, 64'h3000,              1'b0, 64'h0,    1'b1, 1'b1, 64'hC0,   4'd7}, // R7 refresh C
        '{1'b1, 64'h6000,              1'b1, 64'h60,   1'b0, 1'b0, 64'h0,    4'd7},
        '{1'b0, 64'h4000,              1'b0, 64'h0,    1'b0, 1'b0, 64'h0,    4'd7}, // R7 D evicted
        '{1'b0, 64'h3000,              1'b0, 64'h0,    1'b1, 1'b1, 64'hC0,   4'd7}, // R7
        '{1'b0, 64'h6000,              1'b0, 64'h0,    1'b1, 1'b1, 64'h60,   4'd7}  // R7
    };

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // One clock with the given inputs; sample just after the edge
    task automatic step(input logic fl, input logic lv, input logic [63:0] la,
                        input logic uv, input logic [63:0] ua, input logic ut, input logic [63:0] utg);
        @(negedge clk);
        mode_flush = fl;
        lk_valid   = lv;
        lk_addr    = la;
        up_valid   = uv;
        up_addr    = ua;
        up_taken   = ut;
        up_target  = utg;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_rsp(input string rq, input logic h, input logic t, input logic [63:0] g);
        chk(rq, "rsp_valid",  {63'd0, rsp_valid}, 64'd1);
        chk(rq, "rsp_hit",    {63'd0, rsp_hit},   {63'd0, h});
        chk(rq, "rsp_taken",  {63'd0, rsp_taken}, {63'd0, t});
        chk(rq, "rsp_target", rsp_target, g);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        mode_flush = 1'b0; lk_valid = 1'b0; lk_addr = '0;
        up_valid = 1'b0; up_addr = '0; up_taken = 1'b0; up_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1: quiet response after reset
        chk("R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        chk("R1", "rsp_hit after reset",   {63'd0, rsp_hit},   64'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].op == 1'b0) begin
                step(1'b0, 1'b1, VEC[i].addr, 1'b0, 64'h0, 1'b0, 64'h0);
                expect_rsp($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].ehit, VEC[i].etaken, VEC[i].etgt);
            end else begin
                step(1'b0, 1'b0, 64'h0, 1'b1, VEC[i].addr, VEC[i].taken, VEC[i].tgt);
                // R3: no response for a cycle without lookup
                chk($sformatf("R3 vec%0d", i), "rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
            end
        end

        // R10: lookup and update to C together return the old contents
        step(1'b0, 1'b1, 64'h3000, 1'b1, 64'h3000, 1'b1, 64'hCC);
        expect_rsp("R10 same-cycle", 1'b1, 1'b1, 64'hC0);
        step(1'b0, 1'b1, 64'h3000, 1'b0, 64'h0, 1'b0, 64'h0);
        expect_rsp("R10 next", 1'b1, 1'b1, 64'hCC);

        // R8: lookup with flush misses; table empty afterwards
        step(1'b1, 1'b1, 64'h3000, 1'b0, 64'h0, 1'b0, 64'h0);
        expect_rsp("R8 with flush", 1'b0, 1'b0, 64'h0);
        step(1'b0, 1'b1, 64'h3000, 1'b0, 64'h0, 1'b0, 64'h0);
        expect_rsp("R8 after flush C", 1'b0, 1'b0, 64'h0);
        step(1'b0, 1'b1, 64'h6000, 1'b0, 64'h0, 1'b0, 64'h0);
        expect_rsp("R8 after flush G", 1'b0, 1'b0, 64'h0);

        // R9: update during flush is dropped
        step(1'b1, 1'b0, 64'h0, 1'b1, 64'h7000, 1'b1, 64'h77);
        step(1'b0, 1'b1, 64'h7000, 1'b0, 64'h0, 1'b0, 64'h0);
        expect_rsp("R9 dropped", 1'b0, 1'b0, 64'h0);
        step(1'b0, 1'b0, 64'h0, 1'b1, 64'h7000, 1'b1, 64'h77);
        step(1'b0, 1'b1, 64'h7000, 1'b0, 64'h0, 1'b0, 64'h0);
        expect_rsp("R9 refill", 1'b1, 1'b1, 64'h77);

        step(1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule